// File: doc/BRIEF.md
# Two-Thread Tagged Micro-Op Line Store

This block holds decoded micro-op lines for two hardware threads in one shared 8-way set-associative array. Each thread presents its own line pointer on a lookup port. An arbiter picks one thread per cycle, and only that thread's pointer goes to the array. A stored line records the thread that filled it. A lookup therefore hits only on a line owned by the requesting thread, even when the other thread holds a line at the same address.

Lines are written through a fill port. There is no quota per thread. A fill always replaces the least recently used way of its set, ranked over all eight ways whoever owns them. A busy thread can therefore take over a set that the other thread no longer uses. Each lookup is answered one cycle after its grant with a hit flag, the way and the line data.

Top module: `utrace_store`

## Requirements
- R1: While reset is held and after it is released, `rsp_vld` is low, and every lookup made after reset misses.
- R2: When only one thread raises its bit in `lk_req`, that thread is granted in the same cycle. A thread that is not requesting is never granted.
- R3: `lk_gnt` has at most one bit set (bit 0 is thread 0). When both threads request, the grant goes to the thread that was not granted most recently. If no grant has been given since reset, thread 0 wins, so two contending threads alternate every cycle.
- R4: `rsp_vld` is high exactly in the cycle after a cycle with a grant. `rsp_tid` then holds the number of the granted thread.
- R5: The set index is pointer bits [5:0] and the tag is bits [15:6]. A lookup hits only if the way is valid, its tag matches and its owning thread equals the requester. A line filled by the other thread at the same pointer gives a miss.
- R6: On a hit, `rsp_way` is the way that holds the line and `rsp_data` is the data it was filled with. On a miss, both are zero.
- R7: A fill writes its set's least recently used way and makes that way the most recently used. Owner is ignored. After reset, each set ranks way 0 as most recent and way 7 as least recent, so the first fills to a set go to ways 7, 6, ..., 0.
- R8: A hit makes its way the most recently used in that set. Ways ranked more recent than the hit way each move one place older. Other sets keep their order.
- R9: A fill takes effect at the clock edge. A lookup in the same cycle sees the old contents, and a lookup in the next cycle sees the new line. If a same-cycle hit and a fill address the same set, the hit is applied to the order first and the fill victim is then chosen.
- R10: One thread may own all eight ways of a set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_req | input | 2 | Lookup request per thread (bit 0 = thread 0) |
| lk_addr0 | input | ADDR_W | Thread 0 line pointer |
| lk_addr1 | input | ADDR_W | Thread 1 line pointer |
| lk_gnt | output | 2 | Grant this cycle, one-hot or zero |
| fl_vld | input | 1 | Fill strobe |
| fl_tid | input | 1 | Thread that owns the filled line |
| fl_addr | input | ADDR_W | Pointer of the filled line |
| fl_data | input | DATA_W | Line contents |
| rsp_vld | output | 1 | Response for last cycle's grant |
| rsp_tid | output | 1 | Thread the response belongs to |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 3 | Way that hit, zero on miss |
| rsp_data | output | DATA_W | Line data, zero on miss |

## Verification
The grant is combinational and is due in the cycle of the request. The bench checks it one time unit after driving inputs at the falling edge. The response is due one rising edge after the granted cycle, and the bench samples it at the next falling edge. A fill changes the array and the replacement order at the edge that closes its cycle. The bench's reference model therefore applies the lookup, then the hit update, then the fill once per cycle, in that order. Each result is compared in the cycle it is due.

// File: rtl/utrace_pkg.sv
package utrace_pkg;
  localparam int unsigned N_WAYS = 8;
  localparam int unsigned WAY_W  = $clog2(N_WAYS);

  typedef logic [WAY_W-1:0] way_t;
  // rank per way, 0 = most recent, N_WAYS-1 = least recent
  typedef way_t [N_WAYS-1:0] rank_t;

  function automatic rank_t rank_init();
    rank_t o;
    for (int i = 0; i < N_WAYS; i++) o[i] = way_t'(i);
    return o;
  endfunction

  function automatic rank_t rank_touch(rank_t r, way_t w);
    rank_t o;
    o = r;
    for (int i = 0; i < N_WAYS; i++)
      if (r[i] < r[w]) o[i] = r[i] + way_t'(1);
    o[w] = '0;
    return o;
  endfunction

  function automatic way_t rank_oldest(rank_t r);
    way_t o;
    o = '0;
    for (int i = 0; i < N_WAYS; i++)
      if (r[i] == way_t'(N_WAYS - 1)) o = way_t'(i);
    return o;
  endfunction
endpackage

// File: rtl/utrace_arb.sv
module utrace_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  output logic [1:0] gnt
);
  // favour_q high: thread 1 wins the next contention
  logic favour_q, favour_d;

  always_comb begin
    gnt      = req;
    favour_d = favour_q;
    if (req == 2'b11) gnt = favour_q ? 2'b10 : 2'b01;
    if (gnt[0])      favour_d = 1'b1;
    else if (gnt[1]) favour_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    favour_q <= 1'b0;
    else if (|req) favour_q <= favour_d;
  end
endmodule

// File: rtl/utrace_lru.sv
module utrace_lru
  import utrace_pkg::*;
#(
  parameter int SETS = 64,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [SET_W-1:0] hit_set,
  input  way_t             hit_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  output way_t             victim
);
  rank_t rank_q [SETS];
  rank_t rank_d [SETS];
  logic [SETS-1:0] upd;

  rank_t hit_r, hit_t, fill_base, fill_t;

  always_comb begin
    hit_r     = rank_q[hit_set];
    hit_t     = rank_touch(hit_r, hit_way);
    fill_base = (hit_en && hit_set == fill_set) ? hit_t : rank_q[fill_set];
    victim    = rank_oldest(fill_base);
    fill_t    = rank_touch(fill_base, victim);
  end

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      rank_d[s] = rank_q[s];
      upd[s]    = 1'b0;
      if (hit_en && hit_set == SET_W'(s)) begin
        rank_d[s] = hit_t;
        upd[s]    = 1'b1;
      end
      if (fill_en && fill_set == SET_W'(s)) begin
        rank_d[s] = fill_t;
        upd[s]    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rank_q[s] <= rank_init();
    end else begin
      for (int s = 0; s < SETS; s++)
        if (upd[s]) rank_q[s] <= rank_d[s];
    end
  end
endmodule

// File: rtl/utrace_array.sv
module utrace_array
  import utrace_pkg::*;
#(
  parameter int SETS   = 64,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              rd_tid,
  output logic              hit,
  output way_t              hit_way,
  output logic [DATA_W-1:0] hit_data,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  way_t              wr_way,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_tid,
  input  logic [DATA_W-1:0] wr_data
);
  logic [N_WAYS-1:0] vld_q [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][N_WAYS];
  logic              tid_q [SETS][N_WAYS];
  logic [DATA_W-1:0] dat_q [SETS][N_WAYS];
  logic [N_WAYS-1:0] match;

  for (genvar w = 0; w < N_WAYS; w++) begin : g_way
    assign match[w] = vld_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag)
                      && (tid_q[rd_set][w] == rd_tid);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = 0; w < N_WAYS; w++)
      if (match[w]) hit_way = way_t'(w);
    hit_data = hit ? dat_q[rd_set][hit_way] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
      tid_q[wr_set][wr_way] <= wr_tid;
      dat_q[wr_set][wr_way] <= wr_data;
    end
  end
endmodule

// File: rtl/utrace_store.sv
module utrace_store
  import utrace_pkg::*;
#(
  parameter int SETS   = 64,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lk_req,
  input  logic [ADDR_W-1:0] lk_addr0,
  input  logic [ADDR_W-1:0] lk_addr1,
  output logic [1:0]        lk_gnt,
  input  logic              fl_vld,
  input  logic              fl_tid,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic [DATA_W-1:0] fl_data,
  output logic              rsp_vld,
  output logic              rsp_tid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [DATA_W-1:0] rsp_data
);
  // reset: asserted at once, released after two edges
  logic [1:0] rs_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  logic              sel_tid, look_en, arr_hit, hit_v;
  logic [ADDR_W-1:0] sel_addr;
  way_t              arr_way, victim;
  logic [DATA_W-1:0] arr_data;

  utrace_arb u_arb (
    .clk (clk),
    .rst_n (rst_q_n),
    .req (lk_req),
    .gnt (lk_gnt)
  );

  assign look_en  = |lk_gnt;
  assign sel_tid  = lk_gnt[1];
  assign sel_addr = sel_tid ? lk_addr1 : lk_addr0;

  utrace_array #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .rd_set   (sel_addr[SET_W-1:0]),
    .rd_tag   (sel_addr[ADDR_W-1:SET_W]),
    .rd_tid   (sel_tid),
    .hit      (arr_hit),
    .hit_way  (arr_way),
    .hit_data (arr_data),
    .wr_en    (fl_vld),
    .wr_set   (fl_addr[SET_W-1:0]),
    .wr_way   (victim),
    .wr_tag   (fl_addr[ADDR_W-1:SET_W]),
    .wr_tid   (fl_tid),
    .wr_data  (fl_data)
  );

  assign hit_v = look_en && arr_hit;

  utrace_lru #(.SETS(SETS)) u_lru (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .hit_en   (hit_v),
    .hit_set  (sel_addr[SET_W-1:0]),
    .hit_way  (arr_way),
    .fill_en  (fl_vld),
    .fill_set (fl_addr[SET_W-1:0]),
    .victim   (victim)
  );

  logic              vld_d, tid_d, hit_d;
  way_t              way_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    vld_d  = look_en;
    tid_d  = sel_tid;
    hit_d  = hit_v;
    way_d  = hit_v ? arr_way : '0;
    data_d = hit_v ? arr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_vld  <= 1'b0;
      rsp_tid  <= 1'b0;
      rsp_hit  <= 1'b0;
      rsp_way  <= '0;
      rsp_data <= '0;
    end else begin
      rsp_vld <= vld_d;
      if (vld_d) begin
        rsp_tid  <= tid_d;
        rsp_hit  <= hit_d;
        rsp_way  <= way_d;
        rsp_data <= data_d;
      end
    end
  end
endmodule

// File: rtl/utrace_store_chk.sv
module utrace_store_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        lk_req,
  input logic [1:0]        lk_gnt,
  input logic              rsp_vld,
  input logic              rsp_tid,
  input logic              rsp_hit,
  input logic [2:0]        rsp_way,
  input logic [DATA_W-1:0] rsp_data
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R3
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_gnt));

  // R2
  gnt_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_gnt & ~lk_req) == 2'b00);

  // R2
  gnt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req != 2'b00) |-> (lk_gnt != 2'b00));

  // R3
  gnt_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && lk_req == 2'b11 && $past(lk_gnt) != 2'b00) |-> (lk_gnt != $past(lk_gnt)));

  // R4
  rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (rsp_vld == $past(|lk_gnt)));

  // R4
  rsp_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rsp_vld) |-> (rsp_tid == $past(lk_gnt[1])));

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !rsp_hit) |-> (rsp_data == '0 && rsp_way == 3'd0));
endmodule

bind utrace_store utrace_store_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .lk_req   (lk_req),
  .lk_gnt   (lk_gnt),
  .rsp_vld  (rsp_vld),
  .rsp_tid  (rsp_tid),
  .rsp_hit  (rsp_hit),
  .rsp_way  (rsp_way),
  .rsp_data (rsp_data)
);

// File: tb/utrace_store_bench.sv
module utrace_store_bench;
  localparam int SETS = 64;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [1:0]        lk_req, lk_gnt;
  logic [ADDR_W-1:0] lk_addr0, lk_addr1, fl_addr;
  logic              fl_vld, fl_tid;
  logic [DATA_W-1:0] fl_data, rsp_data;
  logic              rsp_vld, rsp_tid, rsp_hit;
  logic [2:0]        rsp_way;

  utrace_store u_utrace_store (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr0(lk_addr0),
    .lk_addr1(lk_addr1), .lk_gnt(lk_gnt), .fl_vld(fl_vld), .fl_tid(fl_tid),
    .fl_addr(fl_addr), .fl_data(fl_data), .rsp_vld(rsp_vld), .rsp_tid(rsp_tid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_data(rsp_data)
  );

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  // reference model
  bit              m_v   [SETS][8];
  int              m_tag [SETS][8];
  bit              m_tid [SETS][8];
  logic [31:0]     m_dat [SETS][8];
  int              m_rank[SETS][8];
  int              m_last;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 8; w++) begin
        m_v[s][w] = 0;
        m_rank[s][w] = w;
      end
    m_last = -1;
  endfunction

  function automatic void m_touch(int s, int w);
    int r;
    r = m_rank[s][w];
    for (int i = 0; i < 8; i++)
      if (m_rank[s][i] < r) m_rank[s][i]++;
    m_rank[s][w] = 0;
  endfunction

  function automatic bit m_has(int s, bit t, int tg);
    for (int w = 0; w < 8; w++)
      if (m_v[s][w] && m_tid[s][w] == t && m_tag[s][w] == tg) return 1;
    return 0;
  endfunction

  task automatic step(input logic [1:0] rq, input logic [15:0] a0, input logic [15:0] a1,
                      input logic fv, input logic ft, input logic [15:0] fa, input logic [31:0] fd);
    logic [1:0] eg;
    bit eh, et;
    int ew, s, tg, vw;
    logic [15:0] a;
    logic [31:0] ed;
    lk_req = rq; lk_addr0 = a0; lk_addr1 = a1;
    fl_vld = fv; fl_tid = ft; fl_addr = fa; fl_data = fd;
    #1;
    if (rq == 2'b11) eg = (m_last == 0) ? 2'b10 : 2'b01;
    else eg = rq;
    chk(lk_gnt == eg, "grant", 64'(lk_gnt), 64'(eg));
    eh = 0; ew = 0; ed = '0; et = eg[1];
    if (eg != 2'b00) begin
      m_last = eg[1] ? 1 : 0;
      a = et ? a1 : a0;
      s = int'(a[5:0]); tg = int'(a[15:6]);
      for (int w = 0; w < 8; w++)
        if (m_v[s][w] && m_tag[s][w] == tg && m_tid[s][w] == et) begin
          eh = 1; ew = w; ed = m_dat[s][w];
        end
      if (eh) m_touch(s, ew);
    end
    if (fv) begin
      s = int'(fa[5:0]);
      vw = 0;
      for (int w = 0; w < 8; w++) if (m_rank[s][w] == 7) vw = w;
      m_v[s][vw] = 1; m_tag[s][vw] = int'(fa[15:6]); m_tid[s][vw] = ft; m_dat[s][vw] = fd;
      m_touch(s, vw);
    end
    @(posedge clk);
    @(negedge clk);
    chk(rsp_vld == (eg != 2'b00), "rsp_vld", 64'(rsp_vld), 64'(eg != 2'b00));
    if (eg != 2'b00)
      chk({rsp_tid, rsp_hit, rsp_way, rsp_data} == {et, eh, 3'(ew), ed}, "tid/hit/way/data",
          64'({rsp_tid, rsp_hit, rsp_way, rsp_data}), 64'({et, eh, 3'(ew), ed}));
  endtask

  function automatic logic [15:0] pa(int tg, int s);
    return {10'(tg), 6'(s)};
  endfunction

  task automatic idle();
    step(2'b00, '0, '0, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired in %s", tag);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    m_reset();
    rst_n = 1'b0;
    lk_req = 2'b11; lk_addr0 = '0; lk_addr1 = '0;
    fl_vld = 1'b0; fl_tid = 1'b0; fl_addr = '0; fl_data = '0;
    repeat (3) @(negedge clk);
    // R1: no response while in reset, even with requests raised
    chk(rsp_vld == 1'b0, "rsp_vld in reset", 64'(rsp_vld), 64'd0);
    lk_req = 2'b00;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rsp_vld == 1'b0, "rsp_vld after reset", 64'(rsp_vld), 64'd0);

    // R1 lookups after reset miss
    tag = "R1";
    step(2'b01, pa(0, 0), pa(0, 0), 0, 0, '0, '0);
    step(2'b10, pa(3, 9), pa(3, 9), 0, 0, '0, '0);

    // R7 R10: thread 1 fills eight lines in set 3, ways 7 down to 0
    tag = "R7";
    for (int i = 0; i < 8; i++) step(2'b00, '0, '0, 1, 1, pa(i + 1, 3), 32'hA000 + i);
    tag = "R10";
    for (int i = 0; i < 8; i++) step(2'b10, '0, pa(i + 1, 3), 0, 0, '0, '0);
    // R5: thread 0 at the same pointers misses
    tag = "R5";
    for (int i = 0; i < 8; i++) step(2'b01, pa(i + 1, 3), '0, 0, 0, '0, '0);

    // R8: hit on tag 1 refreshes it; the next fill evicts tag 2's way instead
    tag = "R8";
    step(2'b10, '0, pa(1, 3), 0, 0, '0, '0);
    step(2'b00, '0, '0, 1, 0, pa(20, 3), 32'hBEEF);
    step(2'b10, '0, pa(2, 3), 0, 0, '0, '0);
    step(2'b10, '0, pa(1, 3), 0, 0, '0, '0);
    step(2'b01, pa(20, 3), '0, 0, 0, '0, '0);

    // R9: same-cycle lookup misses, next cycle hits; hit and fill in one set
    tag = "R9";
    step(2'b01, pa(7, 12), '0, 1, 0, pa(7, 12), 32'h1234);
    step(2'b01, pa(7, 12), '0, 0, 0, '0, '0);
    step(2'b10, '0, pa(3, 3), 1, 1, pa(30, 3), 32'h7777);
    step(2'b10, '0, pa(30, 3), 0, 0, '0, '0);
    step(2'b10, '0, pa(3, 3), 0, 0, '0, '0);

    // R2 R3: grant patterns
    tag = "R2";
    step(2'b01, pa(7, 12), '0, 0, 0, '0, '0);
    step(2'b01, pa(7, 12), '0, 0, 0, '0, '0);
    tag = "R3";
    step(2'b11, pa(7, 12), pa(5, 3), 0, 0, '0, '0);
    step(2'b11, pa(7, 12), pa(5, 3), 0, 0, '0, '0);
    step(2'b11, pa(7, 12), pa(5, 3), 0, 0, '0, '0);
    tag = "R2";
    step(2'b10, '0, pa(5, 3), 0, 0, '0, '0);
    tag = "R3";
    step(2'b11, pa(7, 12), pa(5, 3), 0, 0, '0, '0);
    tag = "R4";
    idle();

    // R6 R4 and the rest: random mix
    tag = "R6";
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] rq;
      logic fv, ft;
      logic [15:0] fa;
      rq = 2'($urandom);
      ft = 1'($urandom);
      fa = pa($urandom % 6, $urandom % 4);
      fv = ($urandom % 3) == 0;
      if (fv && m_has(int'(fa[5:0]), ft, int'(fa[15:6]))) fv = 0;
      step(rq, pa($urandom % 6, $urandom % 4), pa($urandom % 6, $urandom % 4),
           fv, ft, fa, $urandom);
    end
    idle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule